// File: doc/BRIEF.md
# SD Block Transfer Sequencer

This control block runs one data block transfer between the host-side FIFOs and a serial SD data-line engine. A single-cycle start pulse picks the direction. For transmit (towards the card), the sequencer enables the transmit FIFO. It then waits until that FIFO reports full, and only then gives the engine a one-cycle write command. For receive (from the card), it enables the receive FIFO and gives a one-cycle read command in the same cycle.

The engine reports through a level that is high while it is idle and low while it works. The sequencer waits to see that level go low, then treats its return to high as the end of the block. It samples the CRC verdict in that same cycle and records the outcome in a sticky three-bit status register. Software clears the register with a one-cycle clear pulse.

A FIFO fault stops the block. A fault is an empty transmit FIFO during a busy transmit, or a full receive FIFO during a busy receive. The sequencer then drives the write and read commands high together, which tells the engine to abort. It keeps both high until the engine is idle again.

Top module: `sdx_xfer_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, `eng_wr`, `eng_rd`, `txq_en`, `rxq_en` and `irq_stat` are all zero.
- R2: A `tx_go` pulse seen while idle raises `txq_en` in the next cycle. `eng_wr` stays low for as long as `txq_full` has not been sampled high.
- R3: The first clock edge that samples `txq_full` high while the block waits to fill raises `eng_wr` in the next cycle. `eng_wr` is high for exactly one cycle.
- R4: An `rx_go` pulse seen while idle raises `rxq_en` and `eng_rd` together in the next cycle. `eng_rd` is high for exactly one cycle.
- R5: After `eng_idle` has been seen low, the first edge that samples `eng_idle` high ends the transfer. At that edge the active FIFO enable drops and the status bit for the outcome is set.
- R6: The status bits are: bit 0 means completed with a good CRC (`crc_good` high), bit 1 means CRC error (`crc_good` low), and bit 2 means FIFO fault. So a single good transfer reads 1, a bad CRC reads 2 and a fault reads 4.
- R7: A fault sampled while busy raises `eng_wr` and `eng_rd` together in the next cycle. A fault is `txq_empty` high in a transmit, or `rxq_full` high in a receive.
- R8: Once the abort starts, both commands stay high until `eng_idle` is sampled high. At that edge both commands drop, the FIFO enable drops, and only bit 2 is added to the status.
- R9: `txq_en` and `rxq_en` are never high together. The enable of the other direction stays low for the whole transfer.
- R10: A `stat_clr` pulse clears `irq_stat` to zero in the next cycle.
- R11: `tx_go` and `rx_go` pulses that arrive while a transfer is in progress have no effect.
- R12: `eng_idle` high before the engine has been seen busy is not taken as completion. The status stays unchanged and the FIFO enable stays high.
- R13: Status bits are sticky. Outcomes of later transfers are ORed in until `stat_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_go | input | 1 | One-cycle start of a transmit block |
| rx_go | input | 1 | One-cycle start of a receive block |
| txq_full | input | 1 | Transmit FIFO full |
| txq_empty | input | 1 | Transmit FIFO empty |
| rxq_full | input | 1 | Receive FIFO full |
| eng_idle | input | 1 | Serial engine idle level (low while busy) |
| crc_good | input | 1 | CRC verdict, valid in the cycle `eng_idle` returns high |
| stat_clr | input | 1 | One-cycle status clear |
| eng_wr | output | 1 | Write command to the engine (with `eng_rd`: abort) |
| eng_rd | output | 1 | Read command to the engine (with `eng_wr`: abort) |
| txq_en | output | 1 | Transmit FIFO enable |
| rxq_en | output | 1 | Receive FIFO enable |
| irq_stat | output | STAT_W | Sticky status: bit 0 done, bit 1 CRC error, bit 2 FIFO fault |

## Verification
Every output is registered, so each result appears in the cycle after the edge that samples its cause. This covers FIFO enables after a start, the write command after the FIFO is full, the abort after a fault, and the status and enable drop after `eng_idle` returns high. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge, and all outputs are compared with it at the next falling edge. Directed checks are placed one falling edge after the stimulus, or several edges later where a level must hold, for example the pulse widths, the abort hold and the early-idle case.

// File: rtl/sdx_seq_pkg.sv
package sdx_seq_pkg;
  localparam int STAT_W      = 3;
  localparam int BIT_DONE    = 0;
  localparam int BIT_CRCERR  = 1;
  localparam int BIT_FIFOERR = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FILL,
    PH_ARM,
    PH_BUSY,
    PH_ABORT
  } phase_t;
endpackage

// File: rtl/sdx_fault_det.sv
// Decides whether the FIFO of the active direction has failed while the
// engine is moving data.
module sdx_fault_det (
  input  logic busy,
  input  logic dir_tx,
  input  logic txq_empty,
  input  logic rxq_full,
  output logic fault
);
  always_comb begin
    fault = 1'b0;
    if (busy) fault = dir_tx ? txq_empty : rxq_full;
  end
endmodule

// File: rtl/sdx_stat_reg.sv
// Sticky status bits: a clear empties the register, and new events are
// ORed in on top.
module sdx_stat_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] set_mask,
  output logic [W-1:0] stat
);
  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= (clr ? '0 : stat) | set_mask;
  end
endmodule

// File: rtl/sdx_seq_fsm.sv
// Phase controller: starts the engine, tracks when it is busy, and handles
// completion and abort.
module sdx_seq_fsm
  import sdx_seq_pkg::*;
#(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_go,
  input  logic          rx_go,
  input  logic          txq_full,
  input  logic          eng_idle,
  input  logic          crc_good,
  input  logic          fault,
  output logic          eng_wr,
  output logic          eng_rd,
  output logic          txq_en,
  output logic          rxq_en,
  output logic          dir_tx,
  output logic          busy,
  output logic [SW-1:0] set_mask
);
  phase_t ph;

  assign busy = (ph == PH_BUSY);

  always_comb begin
    set_mask = '0;
    if (ph == PH_BUSY && !fault && eng_idle)
      set_mask[crc_good ? BIT_DONE : BIT_CRCERR] = 1'b1;
    if (ph == PH_ABORT && eng_idle)
      set_mask[BIT_FIFOERR] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      eng_wr <= 1'b0;
      eng_rd <= 1'b0;
      txq_en <= 1'b0;
      rxq_en <= 1'b0;
      dir_tx <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (tx_go) begin
            txq_en <= 1'b1;
            dir_tx <= 1'b1;
            ph     <= PH_FILL;
          end else if (rx_go) begin
            rxq_en <= 1'b1;
            eng_rd <= 1'b1;
            dir_tx <= 1'b0;
            ph     <= PH_ARM;
          end
        end
        PH_FILL: begin
          if (txq_full) begin
            eng_wr <= 1'b1;
            ph     <= PH_ARM;
          end
        end
        PH_ARM: begin
          // the command is a single pulse; wait for the engine to go busy
          eng_wr <= 1'b0;
          eng_rd <= 1'b0;
          if (!eng_idle) ph <= PH_BUSY;
        end
        PH_BUSY: begin
          if (fault) begin
            eng_wr <= 1'b1;
            eng_rd <= 1'b1;
            ph     <= PH_ABORT;
          end else if (eng_idle) begin
            txq_en <= 1'b0;
            rxq_en <= 1'b0;
            ph     <= PH_IDLE;
          end
        end
        PH_ABORT: begin
          if (eng_idle) begin
            eng_wr <= 1'b0;
            eng_rd <= 1'b0;
            txq_en <= 1'b0;
            rxq_en <= 1'b0;
            ph     <= PH_IDLE;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdx_xfer_seq.sv
module sdx_xfer_seq #(
  parameter int STAT_W = sdx_seq_pkg::STAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_go,
  input  logic              rx_go,
  input  logic              txq_full,
  input  logic              txq_empty,
  input  logic              rxq_full,
  input  logic              eng_idle,
  input  logic              crc_good,
  input  logic              stat_clr,
  output logic              eng_wr,
  output logic              eng_rd,
  output logic              txq_en,
  output logic              rxq_en,
  output logic [STAT_W-1:0] irq_stat
);
  logic              busy;
  logic              dir_tx;
  logic              fault;
  logic [STAT_W-1:0] set_mask;

  sdx_fault_det u_fault (
    .busy      (busy),
    .dir_tx    (dir_tx),
    .txq_empty (txq_empty),
    .rxq_full  (rxq_full),
    .fault     (fault)
  );

  sdx_seq_fsm #(.SW(STAT_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .tx_go    (tx_go),
    .rx_go    (rx_go),
    .txq_full (txq_full),
    .eng_idle (eng_idle),
    .crc_good (crc_good),
    .fault    (fault),
    .eng_wr   (eng_wr),
    .eng_rd   (eng_rd),
    .txq_en   (txq_en),
    .rxq_en   (rxq_en),
    .dir_tx   (dir_tx),
    .busy     (busy),
    .set_mask (set_mask)
  );

  sdx_stat_reg #(.W(STAT_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .clr      (stat_clr),
    .set_mask (set_mask),
    .stat     (irq_stat)
  );
endmodule

// File: rtl/sdx_xfer_seq_chk.sv
module sdx_xfer_seq_chk #(
  parameter int STAT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              txq_full,
  input logic              eng_idle,
  input logic              stat_clr,
  input logic              eng_wr,
  input logic              eng_rd,
  input logic              txq_en,
  input logic              rxq_en,
  input logic [STAT_W-1:0] irq_stat
);
  assert_wr_gated_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(eng_wr) && !eng_rd) |-> $past(txq_full));

  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(eng_wr) && !eng_rd) |=> !eng_wr);

  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(eng_rd) && !eng_wr) |=> !eng_rd);

  assert_abort_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (eng_wr && eng_rd && !eng_idle) |=> (eng_wr && eng_rd));

  assert_one_dir_R9: assert property (@(posedge clk) disable iff (rst)
    !(txq_en && rxq_en));

  assert_sticky_R13: assert property (@(posedge clk) disable iff (rst)
    !stat_clr |=> ((irq_stat & $past(irq_stat)) == $past(irq_stat)));
endmodule

bind sdx_xfer_seq sdx_xfer_seq_chk #(.STAT_W(STAT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .txq_full (txq_full),
  .eng_idle (eng_idle),
  .stat_clr (stat_clr),
  .eng_wr   (eng_wr),
  .eng_rd   (eng_rd),
  .txq_en   (txq_en),
  .rxq_en   (rxq_en),
  .irq_stat (irq_stat)
);

// File: tb/sdx_xfer_seq_bench.sv
module sdx_xfer_seq_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_go = 0, rx_go = 0, txq_full = 0, txq_empty = 0, rxq_full = 0;
  logic eng_idle = 1, crc_good = 0, stat_clr = 0;
  logic eng_wr, eng_rd, txq_en, rxq_en;
  logic [2:0] irq_stat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  sdx_xfer_seq u_sdx_xfer_seq (
    .clk(clk), .rst(rst), .tx_go(tx_go), .rx_go(rx_go),
    .txq_full(txq_full), .txq_empty(txq_empty), .rxq_full(rxq_full),
    .eng_idle(eng_idle), .crc_good(crc_good), .stat_clr(stat_clr),
    .eng_wr(eng_wr), .eng_rd(eng_rd), .txq_en(txq_en), .rxq_en(rxq_en),
    .irq_stat(irq_stat)
  );

  // behavioural reference: step = 0 idle, 1 waiting full, 2 waiting busy,
  // 3 engine running, 4 aborting
  int step = 0;
  bit is_tx = 0;
  bit m_wr = 0, m_rd = 0, m_txen = 0, m_rxen = 0;
  int m_stat = 0;

  always @(posedge clk) begin
    int add;
    add = 0;
    if (rst) begin
      step = 0; is_tx = 0; m_wr = 0; m_rd = 0; m_txen = 0; m_rxen = 0; m_stat = 0;
    end else begin
      if (step == 0) begin
        if (tx_go) begin is_tx = 1; m_txen = 1; step = 1; end
        else if (rx_go) begin is_tx = 0; m_rxen = 1; m_rd = 1; step = 2; end
      end else if (step == 1) begin
        if (txq_full) begin m_wr = 1; step = 2; end
      end else if (step == 2) begin
        m_wr = 0; m_rd = 0;
        if (!eng_idle) step = 3;
      end else if (step == 3) begin
        if ((is_tx && txq_empty) || (!is_tx && rxq_full)) begin
          m_wr = 1; m_rd = 1; step = 4;
        end else if (eng_idle) begin
          add = crc_good ? 1 : 2; m_txen = 0; m_rxen = 0; step = 0;
        end
      end else begin
        if (eng_idle) begin
          add = 4; m_wr = 0; m_rd = 0; m_txen = 0; m_rxen = 0; step = 0;
        end
      end
      m_stat = (stat_clr ? 0 : m_stat) | add;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 eng_wr vs model", int'(eng_wr), int'(m_wr));
      chk("R4 eng_rd vs model", int'(eng_rd), int'(m_rd));
      chk("R2 txq_en vs model", int'(txq_en), int'(m_txen));
      chk("R9 rxq_en vs model", int'(rxq_en), int'(m_rxen));
      chk("R6 irq_stat vs model", int'(irq_stat), m_stat);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_tx(input bit crc);
    tx_go = 1; tick(); tx_go = 0;
    txq_full = 1; tick(); txq_full = 0;
    tick();
    eng_idle = 0; tick(3);
    eng_idle = 1; crc_good = crc; tick(); crc_good = 0;
  endtask

  task automatic clear_stat;
    stat_clr = 1; tick(); stat_clr = 0;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 eng_wr in reset", int'(eng_wr), 0);
    chk("R1 irq_stat in reset", int'(irq_stat), 0);
    rst = 0;
    tick();
    chk("R1 eng_rd after reset", int'(eng_rd), 0);
    chk("R1 txq_en after reset", int'(txq_en), 0);
    chk("R1 rxq_en after reset", int'(rxq_en), 0);

    // transmit, good CRC
    tx_go = 1; tick(); tx_go = 0;
    chk("R2 txq_en after tx_go", int'(txq_en), 1);
    tick(3);
    chk("R2 eng_wr held until full", int'(eng_wr), 0);
    txq_full = 1; tick(); txq_full = 0;
    chk("R3 eng_wr rises", int'(eng_wr), 1);
    tick();
    chk("R3 eng_wr one cycle", int'(eng_wr), 0);
    tick(3);  // engine still idle: not a completion
    chk("R12 status unchanged", int'(irq_stat), 0);
    chk("R12 txq_en held", int'(txq_en), 1);
    eng_idle = 0; tick(2);
    rx_go = 1; tick(); rx_go = 0;
    chk("R11 rx_go ignored rxq_en", int'(rxq_en), 0);
    chk("R11 rx_go ignored eng_rd", int'(eng_rd), 0);
    tx_go = 1; tick(); tx_go = 0;
    chk("R11 tx_go ignored eng_wr", int'(eng_wr), 0);
    eng_idle = 1; crc_good = 1; tick(); crc_good = 0;
    chk("R5 good crc status", int'(irq_stat), 1);
    chk("R5 txq_en dropped", int'(txq_en), 0);
    chk("R9 rxq_en stayed low", int'(rxq_en), 0);
    clear_stat();
    chk("R10 status cleared", int'(irq_stat), 0);

    // receive, bad CRC
    rx_go = 1; tick(); rx_go = 0;
    chk("R4 rxq_en after rx_go", int'(rxq_en), 1);
    chk("R4 eng_rd after rx_go", int'(eng_rd), 1);
    chk("R9 txq_en low in receive", int'(txq_en), 0);
    tick();
    chk("R4 eng_rd one cycle", int'(eng_rd), 0);
    eng_idle = 0; tick(4);
    eng_idle = 1; crc_good = 0; tick();
    chk("R6 bad crc sets bit 1", int'(irq_stat), 2);
    chk("R5 rxq_en dropped", int'(rxq_en), 0);

    // sticky accumulation
    run_tx(1'b1);
    chk("R13 bits accumulate", int'(irq_stat), 3);
    clear_stat();
    chk("R10 cleared again", int'(irq_stat), 0);

    // transmit underrun
    tx_go = 1; tick(); tx_go = 0;
    txq_full = 1; tick(); txq_full = 0;
    tick();
    eng_idle = 0; tick();
    txq_empty = 1; tick(); txq_empty = 0;
    chk("R7 tx fault eng_wr", int'(eng_wr), 1);
    chk("R7 tx fault eng_rd", int'(eng_rd), 1);
    tick(3);
    chk("R8 abort held wr", int'(eng_wr), 1);
    chk("R8 abort held rd", int'(eng_rd), 1);
    chk("R8 no status during abort", int'(irq_stat), 0);
    eng_idle = 1; tick();
    chk("R8 abort end eng_wr", int'(eng_wr), 0);
    chk("R8 abort end eng_rd", int'(eng_rd), 0);
    chk("R8 fault status", int'(irq_stat), 4);
    chk("R8 txq_en dropped", int'(txq_en), 0);
    clear_stat();

    // receive overrun
    rx_go = 1; tick(); rx_go = 0;
    tick();
    eng_idle = 0; tick(2);
    rxq_full = 1; tick(); rxq_full = 0;
    chk("R7 rx fault both commands", int'(eng_wr & eng_rd), 1);
    tick();
    eng_idle = 1; tick();
    chk("R8 rx fault status", int'(irq_stat), 4);
    chk("R8 rxq_en dropped", int'(rxq_en), 0);
    tick(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule